// File: doc/BRIEF.md
# Temperature Sensor Host Register Bank

This block is the register file a host sees on a three-channel temperature sensor. An upstream bus decoder hands it single-byte register reads and writes. Each access is an address plus a read or write strobe. A conversion engine hands it fresh results for an internal diode and two remote diodes. Each result arrives with a one-cycle valid strobe. The bank serves those results as high/low byte pairs. It also holds the configuration and diode ideality settings, reflects a live status byte, and fires a conversion-start pulse when the host writes the one-shot command. It reports fixed identification bytes, and the product byte is selected by two strap pins.

Some registers are read at one address and written at another. Addresses with no register read as zero, and writes to them are dropped. A high byte and its low byte must come from the same conversion, and a snapshot latch provides this. Reading a pair's high byte copies that pair's current low byte into a hold register. The later low-byte read is served from that hold register, so a conversion that lands between the two reads cannot tear the pair.

Top module: `tsens_regbank`

## Requirements
- R1: After reset, `cfg_out` is 47h, both ideality outputs are 12h, and `oneshot`, `access_err` and `rdata` are 0. Every temperature value and the status byte read as 00h.
- R2: Temperature pairs read at these addresses (high/low): internal 00h/23h, remote 1 01h/10h, remote 2 F8h/F9h, remote 1 extended FAh/FBh, remote 2 extended FCh/FDh. Bits [15:8] of a conversion word are the high byte and bits [7:0] are the low byte.
- R3: Address 02h reads the status input as it was sampled on the clock edge before the read. A write to 02h has no effect.
- R4: Configuration reads at 03h and is written only at 09h. A write to 03h leaves it unchanged.
- R5: A write to 0Fh raises `oneshot` for exactly one cycle, starting the cycle after the write. A read of 0Fh returns 00h.
- R6: Remote 1 and remote 2 ideality are read and written at 27h and 28h respectively.
- R7: EDh reads 04h plus the 2-bit strap value. FEh reads 5Dh and FFh reads 01h. Writes to these addresses have no effect.
- R8: A read of an unmapped address returns 00h, and a write to one changes no register.
- R9: Reading a high byte snapshots that pair's low byte. The next low-byte read returns the snapshot even if a newer conversion arrived in between.
- R10: A low-byte read with no preceding high-byte read returns whatever the snapshot latch last held.
- R11: If a conversion strobe and a high-byte read of the same pair fall in one cycle, the read returns the previous result and snapshots its low byte. The new result is returned by the next high/low read.
- R12: Read data appears on `rdata` on the cycle after `rd_en` and holds until the next accepted read.
- R13: If `rd_en` and `wr_en` are high together, neither access takes effect and `access_err` is high for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| access_err | output | 1 | Pulses after simultaneous read and write strobes |
| id_strap | input | 2 | Product-ID strap pins |
| status_in | input | 8 | Live status byte from the conversion engine |
| int_vld | input | 1 | Internal channel result strobe |
| int_temp | input | 16 | Internal channel result {high, low} |
| rem1_vld | input | 1 | Remote 1 result strobe |
| rem1_temp | input | 16 | Remote 1 result {high, low} |
| rem1_ext | input | 16 | Remote 1 extended-range result {high, low} |
| rem2_vld | input | 1 | Remote 2 result strobe |
| rem2_temp | input | 16 | Remote 2 result {high, low} |
| rem2_ext | input | 16 | Remote 2 extended-range result {high, low} |
| cfg_out | output | 8 | Configuration register value |
| ideal1_out | output | 8 | Remote 1 ideality value |
| ideal2_out | output | 8 | Remote 2 ideality value |
| oneshot | output | 1 | One-cycle conversion-start pulse |

## Verification
The hardest case to reach from the ports is a conversion strobe landing on the same clock edge as a high-byte read of the same pair. There the old result must be returned and snapshotted while the new one is kept. The bench reaches it by raising the valid strobe and the read strobe on the same falling edge. It then checks the old pair, and a second high/low read must return the new pair. The torn-read window is opened on purpose: the bench injects a conversion between a high read and its low read, and then reads a low byte with no high read before it.

// File: rtl/tsens_regbank.sv
module tsens_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          access_err,
  input  logic [1:0]    id_strap,
  input  logic [DW-1:0] status_in,
  input  logic          int_vld,
  input  logic [2*DW-1:0] int_temp,
  input  logic          rem1_vld,
  input  logic [2*DW-1:0] rem1_temp,
  input  logic [2*DW-1:0] rem1_ext,
  input  logic          rem2_vld,
  input  logic [2*DW-1:0] rem2_temp,
  input  logic [2*DW-1:0] rem2_ext,
  output logic [DW-1:0] cfg_out,
  output logic [DW-1:0] ideal1_out,
  output logic [DW-1:0] ideal2_out,
  output logic          oneshot
);

  localparam int NP = 5;
  localparam logic [AW-1:0] A_STATUS = AW'('h02);
  localparam logic [AW-1:0] A_CFG_RD = AW'('h03);
  localparam logic [AW-1:0] A_CFG_WR = AW'('h09);
  localparam logic [AW-1:0] A_ONESHOT = AW'('h0F);
  localparam logic [AW-1:0] A_IDEAL1 = AW'('h27);
  localparam logic [AW-1:0] A_IDEAL2 = AW'('h28);
  localparam logic [AW-1:0] A_PROD = AW'('hED);
  localparam logic [AW-1:0] A_MFG = AW'('hFE);
  localparam logic [AW-1:0] A_REV = AW'('hFF);
  localparam logic [DW-1:0] CFG_RST = DW'('h47);
  localparam logic [DW-1:0] IDEAL_RST = DW'('h12);
  localparam logic [DW-1:0] MFG_VAL = DW'('h5D);
  localparam logic [DW-1:0] REV_VAL = DW'('h01);
  localparam logic [DW-1:0] PROD_BASE = DW'('h04);
  // pair order: internal, remote1, remote2, remote1 ext, remote2 ext
  localparam logic [AW-1:0] HI_A [NP] = '{AW'('h00), AW'('h01), AW'('hF8), AW'('hFA), AW'('hFC)};
  localparam logic [AW-1:0] LO_A [NP] = '{AW'('h23), AW'('h10), AW'('hF9), AW'('hFB), AW'('hFD)};

  logic [DW-1:0] live_hi [NP];
  logic [DW-1:0] live_lo [NP];
  logic [DW-1:0] snap_lo [NP];
  logic [2*DW-1:0] conv_word [NP];
  logic [NP-1:0] conv_vld;
  logic [DW-1:0] status_q, rd_val;
  logic rd_ok, wr_ok;

  assign rd_ok = rd_en & ~wr_en;
  assign wr_ok = wr_en & ~rd_en;
  assign conv_vld = {rem2_vld, rem1_vld, rem2_vld, rem1_vld, int_vld};
  assign conv_word[0] = int_temp;
  assign conv_word[1] = rem1_temp;
  assign conv_word[2] = rem2_temp;
  assign conv_word[3] = rem1_ext;
  assign conv_word[4] = rem2_ext;

  always_comb begin
    rd_val = '0;
    case (addr)
      A_STATUS: rd_val = status_q;
      A_CFG_RD: rd_val = cfg_out;
      A_IDEAL1: rd_val = ideal1_out;
      A_IDEAL2: rd_val = ideal2_out;
      A_PROD:   rd_val = PROD_BASE | DW'(id_strap);
      A_MFG:    rd_val = MFG_VAL;
      A_REV:    rd_val = REV_VAL;
      default:  rd_val = '0;
    endcase
    for (int p = 0; p < NP; p++) begin
      if (addr == HI_A[p]) rd_val = live_hi[p];
      if (addr == LO_A[p]) rd_val = snap_lo[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        live_hi[p] <= '0;
        live_lo[p] <= '0;
        snap_lo[p] <= '0;
      end
      status_q   <= '0;
      rdata      <= '0;
      access_err <= 1'b0;
      oneshot    <= 1'b0;
      cfg_out    <= CFG_RST;
      ideal1_out <= IDEAL_RST;
      ideal2_out <= IDEAL_RST;
    end else begin
      status_q   <= status_in;
      access_err <= rd_en & wr_en;
      oneshot    <= wr_ok && (addr == A_ONESHOT);
      for (int p = 0; p < NP; p++) begin
        if (conv_vld[p]) begin
          live_hi[p] <= conv_word[p][2*DW-1:DW];
          live_lo[p] <= conv_word[p][DW-1:0];
        end
        if (rd_ok && addr == HI_A[p]) snap_lo[p] <= live_lo[p];
      end
      if (rd_ok) rdata <= rd_val;
      if (wr_ok) begin
        case (addr)
          A_CFG_WR: cfg_out    <= wdata;
          A_IDEAL1: ideal1_out <= wdata;
          A_IDEAL2: ideal2_out <= wdata;
          default: ;
        endcase
      end
    end
  end

  assert_cfg_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !rd_en && addr == A_CFG_WR) |=> $stable(cfg_out));
  assert_ideal_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !rd_en && (addr == A_IDEAL1 || addr == A_IDEAL2)) |=> ($stable(ideal1_out) && $stable(ideal2_out)));
  assert_oneshot_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == A_ONESHOT) |=> oneshot);
  assert_oneshot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !oneshot);
  assert_collision_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> (access_err && $stable(rdata)));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  assert_oneshot_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == A_ONESHOT) |=> (rdata == '0));

endmodule

// File: tb/tsens_regbank_test.sv
module tsens_regbank_test;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata, status_in = 0;
  logic [1:0] id_strap = 2'd2;
  logic access_err, oneshot;
  logic int_vld = 0, rem1_vld = 0, rem2_vld = 0;
  logic [15:0] int_temp = 0, rem1_temp = 0, rem1_ext = 0, rem2_temp = 0, rem2_ext = 0;
  logic [7:0] cfg_out, ideal1_out, ideal2_out;

  int checks = 0, fails = 0;
  bit done = 0, pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tsens_regbank uut (.clk, .rst_n, .rd_en, .wr_en, .addr, .wdata, .rdata, .access_err,
    .id_strap, .status_in, .int_vld, .int_temp, .rem1_vld, .rem1_temp, .rem1_ext,
    .rem2_vld, .rem2_temp, .rem2_ext, .cfg_out, .ideal1_out, .ideal2_out, .oneshot);

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rst_n && rd_en && !wr_en;

  always @(negedge clk) if (pend) begin
    if (exp_q.size() == 0) check("R12 unexpected read data", rdata, 8'hxx);
    else check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic conv_all(input logic [15:0] i, input logic [15:0] r1, input logic [15:0] x1,
                          input logic [15:0] r2, input logic [15:0] x2);
    @(negedge clk);
    int_temp = i; rem1_temp = r1; rem1_ext = x1; rem2_temp = r2; rem2_ext = x2;
    int_vld = 1; rem1_vld = 1; rem2_vld = 1;
    @(negedge clk); int_vld = 0; rem1_vld = 0; rem2_vld = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cfg reset", cfg_out, 8'h47);
    check("R1 ideal1 reset", ideal1_out, 8'h12);
    check("R1 ideal2 reset", ideal2_out, 8'h12);
    check("R1 oneshot reset", {7'd0, oneshot}, 8'h00);
    check("R1 err reset", {7'd0, access_err}, 8'h00);
    check("R1 rdata reset", rdata, 8'h00);
    rd(8'h00, 8'h00, "R1 internal high default");
    rd(8'hFD, 8'h00, "R1 ext2 low default");
    rd(8'h02, 8'h00, "R1 status default");
    rd(8'h03, 8'h47, "R1 cfg read default");

    // R2 map
    conv_all(16'h1A2B, 16'h3C4D, 16'h5E6F, 16'h7081, 16'h92A3);
    rd(8'h00, 8'h1A, "R2 int hi"); rd(8'h23, 8'h2B, "R2 int lo");
    rd(8'h01, 8'h3C, "R2 r1 hi");  rd(8'h10, 8'h4D, "R2 r1 lo");
    rd(8'hF8, 8'h70, "R2 r2 hi");  rd(8'hF9, 8'h81, "R2 r2 lo");
    rd(8'hFA, 8'h5E, "R2 x1 hi");  rd(8'hFB, 8'h6F, "R2 x1 lo");
    rd(8'hFC, 8'h92, "R2 x2 hi");  rd(8'hFD, 8'hA3, "R2 x2 lo");

    // R3 status
    @(negedge clk); status_in = 8'hC5;
    rd(8'h02, 8'hC5, "R3 status follows input");
    wr(8'h02, 8'h11);
    rd(8'h02, 8'hC5, "R3 status write ignored");

    // R4 config
    wr(8'h03, 8'hAA);
    check("R4 write at read address ignored", cfg_out, 8'h47);
    wr(8'h09, 8'h3C);
    check("R4 cfg_out after write", cfg_out, 8'h3C);
    rd(8'h03, 8'h3C, "R4 cfg readback");
    rd(8'h09, 8'h00, "R4 write address reads zero");

    // R5 one-shot
    wr(8'h0F, 8'hFF);
    check("R5 oneshot pulse", {7'd0, oneshot}, 8'h01);
    @(negedge clk);
    check("R5 oneshot single cycle", {7'd0, oneshot}, 8'h00);
    rd(8'h0F, 8'h00, "R5 oneshot reads zero");

    // R6 ideality
    wr(8'h27, 8'h15); wr(8'h28, 8'h0E);
    rd(8'h27, 8'h15, "R6 ideal1"); rd(8'h28, 8'h0E, "R6 ideal2");
    check("R6 ideal1 out", ideal1_out, 8'h15);
    check("R6 ideal2 out", ideal2_out, 8'h0E);

    // R7 identification
    rd(8'hED, 8'h06, "R7 product id strap 2");
    @(negedge clk); id_strap = 2'd3;
    rd(8'hED, 8'h07, "R7 product id strap 3");
    wr(8'hFE, 8'h00); wr(8'hFF, 8'h77); wr(8'hED, 8'h00);
    rd(8'hFE, 8'h5D, "R7 mfg id"); rd(8'hFF, 8'h01, "R7 revision");
    rd(8'hED, 8'h07, "R7 product id after write");

    // R8 undefined
    wr(8'h55, 8'h99);
    rd(8'h55, 8'h00, "R8 undefined read");
    rd(8'h04, 8'h00, "R8 undefined read 04");
    check("R8 cfg untouched", cfg_out, 8'h3C);
    check("R8 ideal1 untouched", ideal1_out, 8'h15);
    check("R8 ideal2 untouched", ideal2_out, 8'h0E);

    // R9 snapshot across a new conversion
    rd(8'h01, 8'h3C, "R9 r1 hi snapshot");
    conv_all(16'h1111, 16'hBEEF, 16'h2222, 16'h3333, 16'h4444);
    rd(8'h10, 8'h4D, "R9 r1 lo from snapshot");
    rd(8'hFA, 8'h22, "R9 x1 hi snapshot");
    conv_all(16'h1111, 16'hBEEF, 16'h5566, 16'h3333, 16'h4444);
    rd(8'hFB, 8'h22, "R9 x1 lo from snapshot");

    // R10 low read without high read
    rd(8'hF9, 8'h81, "R10 r2 lo stale latch");
    rd(8'hF8, 8'h33, "R10 r2 hi refresh");
    rd(8'hF9, 8'h33, "R10 r2 lo after refresh");

    // R11 conversion and high read in one cycle
    @(negedge clk);
    addr = 8'h00; rd_en = 1; exp_q.push_back(8'h11); tag_q.push_back("R11 old high returned");
    int_temp = 16'hD00D; int_vld = 1;
    @(negedge clk); rd_en = 0; int_vld = 0;
    rd(8'h23, 8'h11, "R11 old low snapshotted");
    rd(8'h00, 8'hD0, "R11 new high kept");
    rd(8'h23, 8'h0D, "R11 new low kept");

    // R12 hold while idle
    repeat (2) @(negedge clk);
    check("R12 rdata holds when idle", rdata, 8'h0D);

    // R13 collision
    @(negedge clk); addr = 8'h09; wdata = 8'h81; rd_en = 1; wr_en = 1;
    @(negedge clk); rd_en = 0; wr_en = 0;
    check("R13 error flag", {7'd0, access_err}, 8'h01);
    check("R13 rdata unchanged", rdata, 8'h0D);
    check("R13 write blocked", cfg_out, 8'h3C);
    @(negedge clk);
    check("R13 flag single cycle", {7'd0, access_err}, 8'h00);

    repeat (3) @(negedge clk);
    check("R12 all reads answered", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule